// File: doc/BRIEF.md
# Gated Multi-Ratio Clock Divider Bank

This block picks one of two incoming clocks and derives four related clocks from it. The first output carries either the picked clock itself or half of it. The other three run at one half, one quarter and one eighth of its rate. Every divided output comes from a single counter stepped by the picked clock, so edges that several outputs share coincide exactly.

A hold request lets the counter pause and resume mid-count without corrupting phase. The request is captured by a register clocked on the falling edge of the picked clock. Gating therefore only ever changes while that clock is low, and the full-rate output never shows a shortened pulse. An active-low reset forces every output low at once, with no clock edge needed. On release, the bank waits for a falling edge and then brings all four outputs high together on the next rising edge.

The clock pick and the rate choice for the first output are static configuration. They are changed only while reset is held.

Top module: `cdb_divider_bank`

## Requirements
- R1: With `src_pick` at 0 the bank runs from `clk_a`; with `src_pick` at 1 it runs from `clk_b`. The other input clock has no effect on the outputs.
- R2: With `a_half` at 1, `div_a` toggles on each counted rising edge and equals `div_b`. With `a_half` at 0, `div_a` follows the picked clock while counting is enabled and stays low while it is held.
- R3: On each counted rising edge `div_b` toggles. `div_c` toggles on every second counted edge and `div_d` on every fourth. On the first counted edge after reset, all of them go high together.
- R4: Every high pulse on `div_a` in full-rate mode lasts at least half a period of the picked clock, including around hold and release of the hold.
- R5: `hold_req` is sampled on the falling edge of the picked clock. When it is sampled high, the next rising edge does not advance `div_b`, `div_c` or `div_d`, and `div_a` stays low in full-rate mode.
- R6: When `hold_req` is sampled low again, counting resumes from the held state. The output sequence continues as if the held edges had not occurred.
- R7: While `rst_n` is low, all four outputs are low. Driving `rst_n` low clears them immediately, without a clock edge.
- R8: After `rst_n` rises, no output goes high before a falling edge of the picked clock has been seen with reset high. The first high level appears on the rising edge that follows that falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | First candidate input clock |
| clk_b | input | 1 | Second candidate input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge |
| src_pick | input | 1 | Clock choice: 0 selects clk_a, 1 selects clk_b |
| a_half | input | 1 | Rate of div_a: 0 full rate, 1 half rate |
| hold_req | input | 1 | Pause request, sampled on the falling edge of the picked clock |
| div_a | output | 1 | Full-rate or half-rate output |
| div_b | output | 1 | Half-rate output |
| div_c | output | 1 | Quarter-rate output |
| div_d | output | 1 | Eighth-rate output |

## Verification
The properties assume that `src_pick` and `a_half` stay fixed whenever reset is high. They also assume that `hold_req` and `rst_n` never move at the same instant as an edge of the picked clock. The stimulus changes the two configuration inputs only inside a held reset. It moves `hold_req` a few nanoseconds after a rising edge, so it is settled well before the falling edge that samples it. It releases reset either shortly after a rising edge or shortly after a falling edge, so both release cases of R8 occur. Async clearing is checked one nanosecond after reset asserts, away from any clock edge.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
  // Number of binary divider stages behind the picked clock (ratios 2, 4, 8).
  localparam int DIV_STAGES = 3;
  typedef logic [DIV_STAGES-1:0] div_vec_t;
endpackage

// File: rtl/cdb_clk_select.sv
module cdb_clk_select (
  input  logic clk_a,
  input  logic clk_b,
  input  logic src_pick,
  output logic clk_int
);
  // Static selection: src_pick changes only while the bank sits in reset.
  always_comb begin
    if (src_pick) clk_int = clk_b;
    else          clk_int = clk_a;
  end
endmodule

// File: rtl/cdb_run_gate.sv
module cdb_run_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  output logic run_en
);
  logic run_d;

  always_comb begin
    run_d = ~hold_req;
  end

  // Falling-edge register: enable only changes while the clock is low.
  // Reset clears it at once; release takes effect on the next falling edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) run_en <= 1'b0;
    else        run_en <= run_d;
  end
endmodule

// File: rtl/cdb_ratio_counter.sv
module cdb_ratio_counter #(
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  output logic [STAGES-1:0] cnt_q
);
  logic [STAGES-1:0] cnt_d;
  logic [STAGES-1:0] borrow;

  assign borrow[0] = run_en;

  // Down counter: from zero the first step sets every bit, so all ratios
  // rise together; each stage flips when every lower stage borrows.
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    assign cnt_d[g] = cnt_q[g] ^ borrow[g];
    if (g < STAGES - 1) begin : g_chain
      assign borrow[g+1] = borrow[g] & ~cnt_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (run_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cdb_a_select.sv
module cdb_a_select (
  input  logic clk,
  input  logic run_en,
  input  logic a_half,
  input  logic half_bit,
  output logic div_a
);
  // Full-rate path: run_en only moves while clk is low, so the AND
  // passes whole high phases only.
  always_comb begin
    if (a_half) div_a = half_bit;
    else        div_a = clk & run_en;
  end
endmodule

// File: rtl/cdb_divider_bank.sv
module cdb_divider_bank
  import cdb_pkg::*;
(
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_n,
  input  logic src_pick,
  input  logic a_half,
  input  logic hold_req,
  output logic div_a,
  output logic div_b,
  output logic div_c,
  output logic div_d
);
  logic     clk_int;
  logic     run_en;
  div_vec_t cnt;

  cdb_clk_select u_clk_select (
    .clk_a    (clk_a),
    .clk_b    (clk_b),
    .src_pick (src_pick),
    .clk_int  (clk_int)
  );

  cdb_run_gate u_run_gate (
    .clk      (clk_int),
    .rst_n    (rst_n),
    .hold_req (hold_req),
    .run_en   (run_en)
  );

  cdb_ratio_counter #(
    .STAGES (DIV_STAGES)
  ) u_ratio_counter (
    .clk    (clk_int),
    .rst_n  (rst_n),
    .run_en (run_en),
    .cnt_q  (cnt)
  );

  cdb_a_select u_a_select (
    .clk      (clk_int),
    .run_en   (run_en),
    .a_half   (a_half),
    .half_bit (cnt[0]),
    .div_a    (div_a)
  );

  assign div_b = cnt[0];
  assign div_c = cnt[1];
  assign div_d = cnt[2];
endmodule

// File: rtl/cdb_divider_bank_chk.sv
module cdb_divider_bank_chk (
  input logic clk_int,
  input logic rst_n,
  input logic run_en,
  input logic a_half,
  input logic div_a,
  input logic div_b,
  input logic div_c,
  input logic div_d
);
  AST_RESET_CLEAR: assert property (@(posedge clk_int)
    !rst_n |-> !(div_a | div_b | div_c | div_d)); // R7

  AST_B_TOGGLE: assert property (@(posedge clk_int) disable iff (!rst_n)
    run_en |=> (div_b != $past(div_b))); // R3

  AST_C_STEP: assert property (@(posedge clk_int) disable iff (!rst_n)
    (run_en && !div_b) |=> (div_c != $past(div_c))); // R3

  AST_C_KEEP: assert property (@(posedge clk_int) disable iff (!rst_n)
    (run_en && div_b) |=> (div_c == $past(div_c))); // R3

  AST_D_STEP: assert property (@(posedge clk_int) disable iff (!rst_n)
    (run_en && !div_b && !div_c) |=> (div_d != $past(div_d))); // R3

  AST_HOLD_FREEZE: assert property (@(posedge clk_int) disable iff (!rst_n)
    !run_en |=> ({div_b, div_c, div_d} == $past({div_b, div_c, div_d}))); // R5

  AST_A_HALF_MATCH: assert property (@(negedge clk_int) disable iff (!rst_n)
    a_half |-> (div_a == div_b)); // R2
endmodule

bind cdb_divider_bank cdb_divider_bank_chk i_chk (
  .clk_int (clk_int),
  .rst_n   (rst_n),
  .run_en  (run_en),
  .a_half  (a_half),
  .div_a   (div_a),
  .div_b   (div_b),
  .div_c   (div_c),
  .div_d   (div_d)
);

// File: tb/test_cdb_divider_bank.sv
module test_cdb_divider_bank;
  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  always #10 clk_a = ~clk_a;   // 50 MHz
  always #16 clk_b = ~clk_b;

  logic rst_n, src_pick, a_half, hold_req;
  logic div_a, div_b, div_c, div_d;
  logic mon_clk;

  cdb_divider_bank i_cdb_divider_bank (
    .clk_a    (clk_a),
    .clk_b    (clk_b),
    .rst_n    (rst_n),
    .src_pick (src_pick),
    .a_half   (a_half),
    .hold_req (hold_req),
    .div_a    (div_a),
    .div_b    (div_b),
    .div_c    (div_c),
    .div_d    (div_d)
  );

  assign mon_clk = src_pick ? clk_b : clk_a;

  typedef struct {
    logic [3:0] v;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  int   phase  = 0;
  bit   done   = 1'b0;
  time  rise_t = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Expected outputs for the next rising edge, from the ratio rules:
  // first counted edge sets all high, b flips each edge, c every 2, d every 4.
  task automatic expect_item(bit en, string tag);
    exp_t e;
    logic b, c, d;
    int   q;
    if (en) phase++;
    if (phase == 0) begin
      b = 1'b0; c = 1'b0; d = 1'b0;
    end else begin
      q = (phase - 1) % 8;
      b = !q[0]; c = !q[1]; d = !q[2];
    end
    e.v   = {(a_half ? b : en), b, c, d};
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic cycle(bit frz, string tag);
    @(posedge mon_clk);
    #5 hold_req = frz;
    @(negedge mon_clk);
    #1 expect_item(!frz, tag);
  endtask

  task automatic start_run(bit p, bit h, bit late);
    @(posedge mon_clk);
    #3 rst_n = 1'b0;
    hold_req = 1'b0;
    #1 src_pick = p;
    a_half = h;
    phase = 0;
    repeat (3) @(posedge mon_clk);
    #2 chk({div_a, div_b, div_c, div_d} == 4'b0000, "R7", "outputs in reset",
           int'({div_a, div_b, div_c, div_d}), 0);
    if (!late) begin
      @(posedge mon_clk);
      #5 rst_n = 1'b1;
      @(negedge mon_clk);
      #1 expect_item(1'b1, "R8");
    end else begin
      @(negedge mon_clk);
      #3 rst_n = 1'b1;
      expect_item(1'b0, "R8");   // falling edge missed: next rise stays low
    end
  endtask

  task automatic async_reset_check();
    @(posedge mon_clk);
    #3 rst_n = 1'b0;
    #1 chk({div_a, div_b, div_c, div_d} == 4'b0000, "R7", "async clear",
           int'({div_a, div_b, div_c, div_d}), 0);
  endtask

  // Scoreboard monitor: compare after each rising edge of the picked clock.
  always @(posedge mon_clk) begin
    #2;
    if (exp_q.size() != 0) begin : pop_blk
      exp_t e;
      e = exp_q.pop_front();
      chk({div_a, div_b, div_c, div_d} === e.v, e.tag, "outputs {a,b,c,d}",
          int'({div_a, div_b, div_c, div_d}), int'(e.v));
    end
  end

  // R4: full-rate pulse width monitor
  always @(posedge div_a) rise_t = $time;
  always @(negedge div_a) begin
    if (rst_n === 1'b1 && a_half === 1'b0 && !done) begin : width_blk
      int thr;
      thr = src_pick ? 16 : 10;
      chk(int'($time - rise_t) >= thr, "R4", "div_a pulse width",
          int'($time - rise_t), thr);
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_pick = 1'b0; a_half = 1'b0; hold_req = 1'b0;
    #55 chk({div_a, div_b, div_c, div_d} == 4'b0000, "R7", "power-up reset",
            int'({div_a, div_b, div_c, div_d}), 0);

    // Full-rate A from clk_a: ratios, hold, resume, hold bursts
    start_run(1'b0, 1'b0, 1'b0);
    repeat (20) cycle(1'b0, "R3");
    repeat (3)  cycle(1'b1, "R5");
    repeat (12) cycle(1'b0, "R6");
    cycle(1'b1, "R4"); cycle(1'b0, "R4"); cycle(1'b1, "R4");
    cycle(1'b1, "R4"); cycle(1'b0, "R4"); cycle(1'b0, "R6");
    async_reset_check();

    // Half-rate A
    start_run(1'b0, 1'b1, 1'b0);
    repeat (10) cycle(1'b0, "R2");
    repeat (2)  cycle(1'b1, "R5");
    repeat (6)  cycle(1'b0, "R2");
    async_reset_check();

    // Release while the clock is low
    start_run(1'b0, 1'b0, 1'b1);
    repeat (10) cycle(1'b0, "R8");

    // Run from clk_b
    start_run(1'b1, 1'b0, 1'b0);
    repeat (12) cycle(1'b0, "R1");
    cycle(1'b1, "R1");
    repeat (5) cycle(1'b0, "R1");
    start_run(1'b1, 1'b1, 1'b0);
    repeat (10) cycle(1'b0, "R1");

    @(posedge mon_clk);
    #4;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule